// File: doc/BRIEF.md
# Update-Based Snooping Line-State Controller

This block tracks the coherence state of every resident line in a small, directly indexed cache that keeps its copies coherent by broadcasting writes instead of invalidating other copies. A resident line is always in one of four states: exclusive-clean, modified, shared-clean or shared-owner. A line that is not resident simply has no entry. When the local processor writes a line that other caches also hold, only the written word goes out on the bus. Caches that hold the line copy that word into their own data arrays through a word-update strobe.

Ownership of dirty shared data rests with one shared-owner at a time. The most recent writer becomes the owner, and the previous owner drops to shared-clean when it sees the update. Memory is written only when an owner or a modified line is evicted. When one cache supplies a line to another, memory is not written. The shared-line input is sampled in the same cycle as the local bus operation. It picks the fill state on a miss, and it decides whether the writer keeps broadcasting (shared-owner) or continues silently as modified.

Each cycle the controller takes one processor request and one snooped bus operation. All outputs are combinational decisions for that cycle, and the state changes at the next rising clock edge. Address translation and the data RAM are outside this block.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is resident. A read to any address raises bus_rd, and an evict of any address raises no wb.
- R2: Operation codes: cpu_op 0 = none, 1 = read, 2 = write, 3 = evict. snp_op 0 = none, 1 = read, 2 = update, 3 = treated as none. The address splits into a low index field of log2(LINES) bits and a tag field above it. A read hit produces no bus activity. A read miss raises bus_rd with bus_addr equal to cpu_addr, and fills the line exclusive-clean when shared_in is low or shared-clean when it is high.
- R3: A write to an exclusive-clean line produces no bus activity and makes the line modified, so a later evict raises wb.
- R4: A write to a shared-clean or shared-owner line raises bus_upd with the address, word index and data of the write. The line becomes shared-owner if shared_in is high and modified if it is low. Further writes to a modified line raise nothing.
- R5: A write miss raises bus_rd and bus_upd together. The line then becomes shared-owner if shared_in is high and modified if it is low.
- R6: A snooped read that hits raises snp_hold. A modified or shared-owner line also raises flush and ends shared-owner, still dirty and with no memory write. An exclusive-clean line ends shared-clean.
- R7: A snooped update that hits raises snp_hold and upd_we, with upd_word and upd_data taken from the bus. The line ends shared-clean, so a former shared-owner no longer writes back.
- R8: An evict hit raises wb, with wb_addr equal to the line address, only for modified or shared-owner lines. After any evict hit the line is absent.
- R9: A read or write miss whose slot holds a different dirty line raises wb with that line's address in the same cycle as bus_rd.
- R10: When snp_op is a read or an update, the processor request of that cycle is ignored. It produces no bus_rd, bus_upd or wb and changes no state.
- R11: A snooped read or update that misses raises no output and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_op | input | 2 | Processor request code |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_word | input | WSEL_W | Word index of a processor write |
| cpu_wdata | input | DATA_W | Data of a processor write |
| snp_op | input | 2 | Snooped bus operation code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_word | input | WSEL_W | Snooped update word index |
| snp_data | input | DATA_W | Snooped update data |
| shared_in | input | 1 | Wired shared line from other caches |
| bus_rd | output | 1 | Request a line fill on the bus |
| bus_upd | output | 1 | Broadcast a single-word update |
| bus_addr | output | ADDR_W | Address of bus_rd / bus_upd |
| bus_word | output | WSEL_W | Word index of bus_upd |
| bus_data | output | DATA_W | Data of bus_upd |
| flush | output | 1 | Supply the line to a snooped read |
| wb | output | 1 | Write a dirty line back to memory |
| wb_addr | output | ADDR_W | Address of the written-back line |
| snp_hold | output | 1 | This cache holds the snooped line (drives shared) |
| upd_we | output | 1 | Patch one word of the local data array |
| upd_word | output | WSEL_W | Word index to patch |
| upd_data | output | DATA_W | Data to patch |

## Verification
A wrong stored state appears at the ports only when the next operation touches the line. Each possible state leaves a different mark on those operations: a missing or extra bus_upd on the next write, a missing or extra flush on a snooped read, and a missing or extra wb on eviction. The bench therefore follows every state change with random reads, writes, evictions and snoops over two tags per index, so an error usually shows within a few cycles. Directed sequences force the cases that random traffic reaches rarely. These are the owner handover, the victim writeback on a miss, and a snoop that arrives in the same cycle as a processor request.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;
   typedef enum logic [1:0] {
      ST_EXC = 2'd0,
      ST_MOD = 2'd1,
      ST_SHC = 2'd2,
      ST_SHM = 2'd3
   } line_st_t;

   typedef enum logic [1:0] {
      CPU_NOP   = 2'd0,
      CPU_RD    = 2'd1,
      CPU_WR    = 2'd2,
      CPU_EVICT = 2'd3
   } cpu_op_t;

   typedef enum logic [1:0] {
      SNP_NONE = 2'd0,
      SNP_RD   = 2'd1,
      SNP_UPD  = 2'd2,
      SNP_RSVD = 2'd3
   } snp_op_t;

   function automatic logic st_dirty(line_st_t s);
      return (s == ST_MOD) || (s == ST_SHM);
   endfunction
endpackage

// File: rtl/upd_coh_table.sv
module upd_coh_table
   import upd_coh_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 9,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic             a_vld,
   output logic [TAG_W-1:0] a_tag,
   output line_st_t         a_st,
   input  logic [IDX_W-1:0] b_idx,
   output logic             b_vld,
   output logic [TAG_W-1:0] b_tag,
   output line_st_t         b_st,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  logic             w_vld,
   input  logic [TAG_W-1:0] w_tag,
   input  line_st_t         w_st
);
   typedef struct packed {
      logic             vld;
      logic [TAG_W-1:0] tag;
      line_st_t         st;
   } slot_t;

   slot_t slots [LINES];

   for (genvar e = 0; e < LINES; e++) begin : g_slot
      slot_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '{vld: 1'b0, tag: '0, st: ST_EXC};
         else if (we && (w_idx == IDX_W'(e)))
            q <= '{vld: w_vld, tag: w_tag, st: w_st};
      end
      assign slots[e] = q;
   end

   assign a_vld = slots[a_idx].vld;
   assign a_tag = slots[a_idx].tag;
   assign a_st  = slots[a_idx].st;
   assign b_vld = slots[b_idx].vld;
   assign b_tag = slots[b_idx].tag;
   assign b_st  = slots[b_idx].st;
endmodule

// File: rtl/upd_coh_decide.sv
module upd_coh_decide
   import upd_coh_pkg::*;
#(
   parameter int TAG_W = 9
) (
   input  cpu_op_t          cpu_op,
   input  logic [TAG_W-1:0] cpu_tag,
   input  logic             cs_vld,
   input  logic [TAG_W-1:0] cs_tag,
   input  line_st_t         cs_st,
   input  snp_op_t          snp_op,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic             ss_vld,
   input  logic [TAG_W-1:0] ss_tag,
   input  line_st_t         ss_st,
   input  logic             shared_in,
   output logic             bus_rd,
   output logic             bus_upd,
   output logic             flush,
   output logic             wb,
   output logic             snp_hold,
   output logic             upd_we,
   output logic             tw_we,
   output logic             tw_from_snp,
   output logic             tw_vld,
   output line_st_t         tw_st
);
   logic cpu_hit, snp_hit, snp_act, victim_dirty;

   assign cpu_hit      = cs_vld && (cs_tag == cpu_tag);
   assign snp_hit      = ss_vld && (ss_tag == snp_tag);
   assign snp_act      = (snp_op == SNP_RD) || (snp_op == SNP_UPD);
   assign victim_dirty = cs_vld && st_dirty(cs_st);

   always_comb begin
      bus_rd      = 1'b0;
      bus_upd     = 1'b0;
      flush       = 1'b0;
      wb          = 1'b0;
      snp_hold    = 1'b0;
      upd_we      = 1'b0;
      tw_we       = 1'b0;
      tw_from_snp = 1'b0;
      tw_vld      = 1'b0;
      tw_st       = ST_EXC;
      if (snp_act) begin
         if (snp_hit) begin
            snp_hold    = 1'b1;
            tw_we       = 1'b1;
            tw_from_snp = 1'b1;
            tw_vld      = 1'b1;
            if (snp_op == SNP_RD) begin
               flush = st_dirty(ss_st);
               tw_st = st_dirty(ss_st) ? ST_SHM : ST_SHC;
            end else begin
               upd_we = 1'b1;
               tw_st  = ST_SHC;
            end
         end
      end else begin
         case (cpu_op)
            CPU_RD: begin
               if (!cpu_hit) begin
                  bus_rd = 1'b1;
                  wb     = victim_dirty;
                  tw_we  = 1'b1;
                  tw_vld = 1'b1;
                  tw_st  = shared_in ? ST_SHC : ST_EXC;
               end
            end
            CPU_WR: begin
               tw_we  = 1'b1;
               tw_vld = 1'b1;
               if (!cpu_hit) begin
                  bus_rd  = 1'b1;
                  bus_upd = 1'b1;
                  wb      = victim_dirty;
                  tw_st   = shared_in ? ST_SHM : ST_MOD;
               end else if ((cs_st == ST_SHC) || (cs_st == ST_SHM)) begin
                  bus_upd = 1'b1;
                  tw_st   = shared_in ? ST_SHM : ST_MOD;
               end else begin
                  tw_st = ST_MOD;
               end
            end
            CPU_EVICT: begin
               if (cpu_hit) begin
                  wb    = st_dirty(cs_st);
                  tw_we = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int ADDR_W = 12,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cpu_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WSEL_W-1:0] cpu_word,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [1:0]        snp_op,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [WSEL_W-1:0] snp_word,
   input  logic [DATA_W-1:0] snp_data,
   input  logic              shared_in,
   output logic              bus_rd,
   output logic              bus_upd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [WSEL_W-1:0] bus_word,
   output logic [DATA_W-1:0] bus_data,
   output logic              flush,
   output logic              wb,
   output logic [ADDR_W-1:0] wb_addr,
   output logic              snp_hold,
   output logic              upd_we,
   output logic [WSEL_W-1:0] upd_word,
   output logic [DATA_W-1:0] upd_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      assert (LINES >= 2 && (1 << IDX_W) == LINES)
         else $error("LINES must be a power of two, at least 2");
      assert (WORDS >= 2 && (1 << WSEL_W) == WORDS)
         else $error("WORDS must be a power of two, at least 2");
      assert (ADDR_W > IDX_W) else $error("ADDR_W must exceed the index width");
      assert (DATA_W > 0) else $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0] cpu_idx, snp_idx, w_idx;
   logic [TAG_W-1:0] cpu_tag, snp_tag, w_tag, cs_tag, ss_tag;
   logic             cs_vld, ss_vld, tw_we, tw_from_snp, tw_vld;
   line_st_t         cs_st, ss_st, tw_st;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
   assign w_idx   = tw_from_snp ? snp_idx : cpu_idx;
   assign w_tag   = tw_from_snp ? snp_tag : cpu_tag;

   upd_coh_table #(.LINES(LINES), .TAG_W(TAG_W)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .a_idx (cpu_idx),
      .a_vld (cs_vld),
      .a_tag (cs_tag),
      .a_st  (cs_st),
      .b_idx (snp_idx),
      .b_vld (ss_vld),
      .b_tag (ss_tag),
      .b_st  (ss_st),
      .we    (tw_we),
      .w_idx (w_idx),
      .w_vld (tw_vld),
      .w_tag (w_tag),
      .w_st  (tw_st)
   );

   upd_coh_decide #(.TAG_W(TAG_W)) u_decide (
      .cpu_op      (cpu_op_t'(cpu_op)),
      .cpu_tag     (cpu_tag),
      .cs_vld      (cs_vld),
      .cs_tag      (cs_tag),
      .cs_st       (cs_st),
      .snp_op      (snp_op_t'(snp_op)),
      .snp_tag     (snp_tag),
      .ss_vld      (ss_vld),
      .ss_tag      (ss_tag),
      .ss_st       (ss_st),
      .shared_in   (shared_in),
      .bus_rd      (bus_rd),
      .bus_upd     (bus_upd),
      .flush       (flush),
      .wb          (wb),
      .snp_hold    (snp_hold),
      .upd_we      (upd_we),
      .tw_we       (tw_we),
      .tw_from_snp (tw_from_snp),
      .tw_vld      (tw_vld),
      .tw_st       (tw_st)
   );

   assign bus_addr = cpu_addr;
   assign bus_word = cpu_word;
   assign bus_data = cpu_wdata;
   assign wb_addr  = {cs_tag, cpu_idx};
   assign upd_word = snp_word;
   assign upd_data = snp_data;

   // ---------------- assertions ----------------
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6: data is supplied only in answer to a snooped read of a held line
   a_r6_flush_on_snoop_read: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (snp_op == 2'd1) && snp_hold);

   // R7: local word patch happens only for a snooped update
   a_r7_patch_on_update: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |-> (snp_op == 2'd2));

   // R10: a processor request coinciding with a snoop produces no bus traffic
   a_r10_cpu_quiet_under_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      ((snp_op == 2'd1) || (snp_op == 2'd2)) |-> !(bus_rd || bus_upd || wb));

   // R4: after a write that saw no sharers, the next write to the line is silent
   a_r4_no_rebroadcast: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cpu_op == 2'd2 && snp_op == 2'd0 && cpu_addr == $past(cpu_addr)
       && $past(cpu_op == 2'd2 && snp_op == 2'd0 && !shared_in)) |-> !bus_upd);

   // R8: an evicted line is gone, so a repeated evict writes nothing back
   a_r8_evict_once: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cpu_op == 2'd3 && snp_op == 2'd0 && cpu_addr == $past(cpu_addr)
       && $past(cpu_op == 2'd3 && snp_op == 2'd0)) |-> !wb);
endmodule

// File: tb/upd_coh_ctrl_test.sv
module upd_coh_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int LINES  = 8;
   localparam int ADDR_W = 12;
   localparam int WSEL_W = 2;
   localparam int DATA_W = 32;
   localparam int EXC = 0, MOD = 1, SHC = 2, SHM = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cpu_op = '0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [WSEL_W-1:0] cpu_word = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [1:0]        snp_op = '0;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic [WSEL_W-1:0] snp_word = '0;
   logic [DATA_W-1:0] snp_data = '0;
   logic              shared_in = 1'b0;
   logic              bus_rd, bus_upd, flush, wb, snp_hold, upd_we;
   logic [ADDR_W-1:0] bus_addr, wb_addr;
   logic [WSEL_W-1:0] bus_word, upd_word;
   logic [DATA_W-1:0] bus_data, upd_data;

   int checks = 0;
   int errors = 0;
   bit m_vld [LINES];
   int m_tag [LINES];
   int m_st  [LINES];

   always #(CLK_PERIOD / 2) clk = ~clk;

   upd_coh_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
      .snp_op(snp_op), .snp_addr(snp_addr), .snp_word(snp_word), .snp_data(snp_data),
      .shared_in(shared_in),
      .bus_rd(bus_rd), .bus_upd(bus_upd), .bus_addr(bus_addr), .bus_word(bus_word),
      .bus_data(bus_data), .flush(flush), .wb(wb), .wb_addr(wb_addr),
      .snp_hold(snp_hold), .upd_we(upd_we), .upd_word(upd_word), .upd_data(upd_data)
   );

   function automatic bit is_dirty(int s);
      return (s == MOD) || (s == SHM);
   endfunction

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic step(input int cop, input int caddr, input int cword, input logic [31:0] cdata,
                       input int sop, input int saddr, input int sword, input logic [31:0] sdata,
                       input bit shr, input string req);
      bit e_rd, e_upd, e_fl, e_wb, e_hold, e_we;
      int idx, tag, nst;
      bit wr_tbl, nvld, hit;
      logic [6:0] e_ctl;
      logic [97:0] act_v, exp_v;
      logic [ADDR_W-1:0] e_wba;
      cpu_op = cop[1:0]; cpu_addr = caddr[ADDR_W-1:0]; cpu_word = cword[WSEL_W-1:0];
      cpu_wdata = cdata; snp_op = sop[1:0]; snp_addr = saddr[ADDR_W-1:0];
      snp_word = sword[WSEL_W-1:0]; snp_data = sdata; shared_in = shr;
      #1;
      {e_rd, e_upd, e_fl, e_wb, e_hold, e_we} = '0;
      wr_tbl = 0; nvld = 0; nst = EXC; e_wba = '0;
      if (sop == 1 || sop == 2) begin
         idx = saddr % LINES; tag = saddr / LINES;
         hit = m_vld[idx] && m_tag[idx] == tag;
         if (hit) begin
            e_hold = 1; wr_tbl = 1; nvld = 1;
            if (sop == 1) begin
               e_fl = is_dirty(m_st[idx]);
               nst = is_dirty(m_st[idx]) ? SHM : SHC;
            end else begin
               e_we = 1; nst = SHC;
            end
         end
      end else begin
         idx = caddr % LINES; tag = caddr / LINES;
         hit = m_vld[idx] && m_tag[idx] == tag;
         e_wba = ADDR_W'(m_tag[idx] * LINES + idx);
         if (cop == 1 && !hit) begin
            e_rd = 1; e_wb = m_vld[idx] && is_dirty(m_st[idx]);
            wr_tbl = 1; nvld = 1; nst = shr ? SHC : EXC;
         end else if (cop == 2) begin
            wr_tbl = 1; nvld = 1;
            if (!hit) begin
               e_rd = 1; e_upd = 1; e_wb = m_vld[idx] && is_dirty(m_st[idx]);
               nst = shr ? SHM : MOD;
            end else if (m_st[idx] == SHC || m_st[idx] == SHM) begin
               e_upd = 1; nst = shr ? SHM : MOD;
            end else nst = MOD;
         end else if (cop == 3 && hit) begin
            e_wb = is_dirty(m_st[idx]); wr_tbl = 1; nvld = 0;
         end
      end
      e_ctl = {1'b0, e_rd, e_upd, e_fl, e_wb, e_hold, e_we};
      act_v = {bus_rd, bus_upd, flush, wb, snp_hold, upd_we,
               (bus_rd | bus_upd) ? bus_addr : '0,
               bus_upd ? {bus_word, bus_data} : 34'd0,
               wb ? wb_addr : '0,
               upd_we ? {upd_word, upd_data} : 34'd0};
      exp_v = {e_ctl[5:0],
               (e_rd | e_upd) ? ADDR_W'(caddr) : '0,
               e_upd ? {WSEL_W'(cword), cdata} : 34'd0,
               e_wb ? e_wba : '0,
               e_we ? {WSEL_W'(sword), sdata} : 34'd0};
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (cpu_op=%0d snp_op=%0d)", req, act_v, exp_v, cop, sop);
      end
      if (wr_tbl) begin
         m_vld[idx] = nvld; m_tag[idx] = tag; m_st[idx] = nst;
      end
      @(negedge clk);
   endtask

   function automatic string label(int cop, int sop);
      if (sop == 1) return "R6";
      if (sop == 2) return "R7";
      if (cop == 1) return "R2";
      if (cop == 2) return "R4";
      if (cop == 3) return "R8";
      return "R11";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
   end

   initial begin
      localparam int A = 9, B = 3, C = 5, D = 13;
      for (int i = 0; i < LINES; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_st[i] = EXC; end
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      step(3, A, 0, 0, 0, 0, 0, 0, 0, "R1");
      step(1, A, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(1, A, 0, 0, 0, 0, 0, 0, 1, "R2");
      step(2, A, 1, 32'h1111_0001, 0, 0, 0, 0, 1, "R3");
      step(3, A, 0, 0, 0, 0, 0, 0, 0, "R3");
      step(1, A, 0, 0, 0, 0, 0, 0, 1, "R2");
      step(2, A, 2, 32'hA5A5_0002, 0, 0, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 1, A, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 2, A, 1, 32'hBEEF_0003, 0, "R7");
      step(3, A, 0, 0, 0, 0, 0, 0, 0, "R7");
      step(1, A, 0, 0, 0, 0, 0, 0, 1, "R2");
      step(2, A, 3, 32'h0000_0004, 0, 0, 0, 0, 0, "R4");
      step(2, A, 0, 32'h0000_0005, 0, 0, 0, 0, 1, "R4");
      step(2, A, 1, 32'h0000_0006, 1, A, 0, 0, 1, "R10");
      step(2, A, 1, 32'h0000_0007, 0, 0, 0, 0, 1, "R6");
      step(0, 0, 0, 0, 1, B, 0, 0, 0, "R11");
      step(0, 0, 0, 0, 2, B, 2, 32'h0000_0008, 0, "R11");
      step(2, C, 2, 32'hC0DE_0009, 0, 0, 0, 0, 1, "R5");
      step(1, D, 0, 0, 0, 0, 0, 0, 0, "R9");
      step(3, A, 0, 0, 0, 0, 0, 0, 0, "R8");
      for (int n = 0; n < 3000; n++) begin
         int cop, sop;
         cop = $urandom_range(0, 3);
         sop = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
         step(cop, $urandom_range(0, 15), $urandom_range(0, 3), $urandom,
              sop, $urandom_range(0, 15), $urandom_range(0, 3), $urandom,
              $urandom_range(0, 1) == 1, label(cop, sop));
      end
      report();
      $finish;
   end
endmodule